// File: doc/BRIEF.md
# Pipeline Hazard and Bypass Controller

This block is the hazard control for a five-stage in-order pipeline (fetch, decode, execute, memory, writeback). It reads the register numbers, write enables and load flags held in the pipeline registers. From these it drives three outputs for the datapath:

- two-bit bypass selects for the two execute-stage ALU operands and for store data;
- a hold signal for the fetch and decode registers, with a matching bubble into execute;
- a flush that turns the instruction fetched behind a taken branch into a no-op.

Conditional branches are compared in decode by a comparator inside this block. That comparator can take the memory-stage ALU result as a bypass. Fetch always continues down the fall-through path, so a taken branch costs one cycle.

The register file writes early in a cycle and reads late in it. A value in writeback is therefore already visible to decode and never needs a bypass or a stall. A mode input turns all bypassing off; dependent instructions then wait until their producer reaches writeback. The select encoding is: 00 register file, 01 memory-stage ALU result, 10 writeback-stage result.

The block has no data stream and no handshake. Every pin is a plain level control, and all outputs are combinational in the current inputs. The only exception is the bypass mode, which is registered.

Top module: `hazard_fwd_unit`

## Requirements
- R1: When the memory-stage instruction writes a non-load result to a register that an execute-stage operand reads, that operand's select is 01 and there is no stall.
- R2: When only the writeback-stage instruction writes the register read by an execute-stage operand, the select is 10. If the memory stage and the writeback stage both write it, the memory-stage value (select 01) wins.
- R3: Register 0 never produces a bypass select other than 00, never causes a stall and is never bypassed into the comparator.
- R4: When the execute instruction is a store, the store-data select follows its second source register under the same rules as R1 and R2, independent of whether ALU operand B reads a register.
- R5: A writeback-stage write to a register read in decode causes neither a stall nor a comparator bypass.
- R6: A decode instruction reading the destination of a load in execute raises stall_fd and bubble_ex for that cycle. Once the load has moved to memory, a non-branch reader is no longer stalled.
- R7: With bypassing off, all selects are 00. Decode stalls while a matching writer sits in execute or memory, which gives two stall cycles for a consumer directly behind its producer. bypass_en is captured on the clock and takes effect the cycle after it is driven. Reset leaves bypassing on.
- R8: The comparator resolves in decode. Kind 01 is taken when the two sources are equal and kind 10 when they differ; kind 00 means no branch. A taken branch raises br_flush only when decode is not stalled (stall has priority).
- R9: A branch source written by a non-load instruction in the memory stage is compared using mem_alu_val rather than the register file value.
- R10: A branch stalls in decode while its source is written by any instruction in execute or by a load in memory, and br_flush stays low while it waits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bypass_en | input | 1 | Bypass mode request, registered |
| id_src_a | input | RW | Decode source register A |
| id_src_b | input | RW | Decode source register B |
| id_use_a | input | 1 | Decode reads source A |
| id_use_b | input | 1 | Decode reads source B |
| id_br | input | 2 | Branch kind: 00 none, 01 equal, 10 not equal |
| id_rf_a | input | DW | Register file value for source A |
| id_rf_b | input | DW | Register file value for source B |
| ex_src_a | input | RW | Execute source register A |
| ex_src_b | input | RW | Execute source register B |
| ex_use_a | input | 1 | ALU operand A reads a register |
| ex_use_b | input | 1 | ALU operand B reads a register |
| ex_store | input | 1 | Execute instruction is a store |
| ex_dst | input | RW | Execute destination register |
| ex_wr | input | 1 | Execute instruction writes a register |
| ex_load | input | 1 | Execute instruction is a load |
| mem_dst | input | RW | Memory-stage destination register |
| mem_wr | input | 1 | Memory-stage instruction writes a register |
| mem_load | input | 1 | Memory-stage instruction is a load |
| mem_alu_val | input | DW | ALU result held after execute |
| wb_dst | input | RW | Writeback destination register |
| wb_wr | input | 1 | Writeback instruction writes a register |
| fwd_a | output | 2 | ALU operand A select |
| fwd_b | output | 2 | ALU operand B select |
| fwd_st | output | 2 | Store data select |
| stall_fd | output | 1 | Hold fetch and decode registers |
| bubble_ex | output | 1 | Insert a no-op into execute |
| br_flush | output | 1 | Taken branch: squash the fetched instruction |

## Verification
Selects, stall, bubble and flush are combinational. They are due in the same cycle the pipeline fields are presented, so the driver applies each pattern just after a rising edge and the monitor compares at the following falling edge. The bypass mode is the one registered path. A change to bypass_en is checked under the old mode in the cycle it is driven and under the new mode from the next cycle on. Multi-cycle behaviour, such as the one-cycle load stall and the two-cycle stall without bypassing, is checked by presenting the pipeline contents of successive cycles as the instructions advance, with one expected item per cycle.

// File: rtl/hfu_pkg.sv
package hfu_pkg;
  typedef enum logic [1:0] {
    SEL_RF  = 2'b00,
    SEL_MEM = 2'b01,
    SEL_WB  = 2'b10
  } fwd_sel_e;

  typedef enum logic [1:0] {
    BR_NONE = 2'b00,
    BR_EQ   = 2'b01,
    BR_NE   = 2'b10
  } br_kind_e;
endpackage

// File: rtl/hfu_op_fwd.sv
module hfu_op_fwd
  import hfu_pkg::*;
#(
  parameter int RW = 5
) (
  input  logic [RW-1:0] src,
  input  logic          reads,
  input  logic          bypass_on,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wr,
  input  logic          mem_load,
  input  logic [RW-1:0] wb_dst,
  input  logic          wb_wr,
  output fwd_sel_e      sel
);
  localparam logic [RW-1:0] ZERO_REG = '0;

  logic live, hit_mem, hit_wb;

  always_comb begin
    live    = reads && bypass_on && (src != ZERO_REG);
    hit_mem = live && mem_wr && !mem_load && (mem_dst == src);
    hit_wb  = live && wb_wr && (wb_dst == src);
    if (hit_mem)     sel = SEL_MEM;
    else if (hit_wb) sel = SEL_WB;
    else             sel = SEL_RF;
  end
endmodule

// File: rtl/hfu_stall_ctl.sv
module hfu_stall_ctl #(
  parameter int RW = 5
) (
  input  logic [RW-1:0] id_src_a,
  input  logic [RW-1:0] id_src_b,
  input  logic          id_use_a,
  input  logic          id_use_b,
  input  logic          id_is_br,
  input  logic          bypass_on,
  input  logic [RW-1:0] ex_dst,
  input  logic          ex_wr,
  input  logic          ex_load,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wr,
  input  logic          mem_load,
  output logic          stall
);
  localparam logic [RW-1:0] ZERO_REG = '0;

  logic rd_a, rd_b, ex_hit, mem_hit;
  logic load_use, br_wait, plain_wait;

  always_comb begin
    rd_a = (id_use_a || id_is_br) && (id_src_a != ZERO_REG);
    rd_b = (id_use_b || id_is_br) && (id_src_b != ZERO_REG);
    ex_hit  = ex_wr && ((rd_a && ex_dst == id_src_a) || (rd_b && ex_dst == id_src_b));
    mem_hit = mem_wr && ((rd_a && mem_dst == id_src_a) || (rd_b && mem_dst == id_src_b));
    load_use   = ex_hit && ex_load;
    br_wait    = id_is_br && (ex_hit || (mem_hit && mem_load));
    plain_wait = ex_hit || mem_hit;
    stall = bypass_on ? (load_use || br_wait) : plain_wait;
  end
endmodule

// File: rtl/hfu_branch_cmp.sv
module hfu_branch_cmp
  import hfu_pkg::*;
#(
  parameter int RW = 5,
  parameter int DW = 32
) (
  input  br_kind_e      kind,
  input  logic [RW-1:0] src_a,
  input  logic [RW-1:0] src_b,
  input  logic [DW-1:0] rf_a,
  input  logic [DW-1:0] rf_b,
  input  logic          bypass_on,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wr,
  input  logic          mem_load,
  input  logic [DW-1:0] mem_alu_val,
  input  logic          stall,
  output logic          flush
);
  localparam int NSRC = 2;
  localparam logic [RW-1:0] ZERO_REG = '0;

  logic [RW-1:0] srcs [NSRC];
  logic [DW-1:0] rfv  [NSRC];
  logic [DW-1:0] opv  [NSRC];

  assign srcs[0] = src_a;
  assign srcs[1] = src_b;
  assign rfv[0]  = rf_a;
  assign rfv[1]  = rf_b;

  for (genvar i = 0; i < NSRC; i++) begin : g_src
    logic take_mem;
    assign take_mem = bypass_on && mem_wr && !mem_load &&
                      (srcs[i] != ZERO_REG) && (mem_dst == srcs[i]);
    assign opv[i] = take_mem ? mem_alu_val : rfv[i];
  end

  logic same, taken;
  always_comb begin
    same = (opv[0] == opv[1]);
    case (kind)
      BR_EQ:   taken = same;
      BR_NE:   taken = !same;
      default: taken = 1'b0;
    endcase
    flush = taken && !stall;
  end
endmodule

// File: rtl/hazard_fwd_unit.sv
module hazard_fwd_unit
  import hfu_pkg::*;
#(
  parameter int RW = 5,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bypass_en,
  input  logic [RW-1:0] id_src_a,
  input  logic [RW-1:0] id_src_b,
  input  logic          id_use_a,
  input  logic          id_use_b,
  input  logic [1:0]    id_br,
  input  logic [DW-1:0] id_rf_a,
  input  logic [DW-1:0] id_rf_b,
  input  logic [RW-1:0] ex_src_a,
  input  logic [RW-1:0] ex_src_b,
  input  logic          ex_use_a,
  input  logic          ex_use_b,
  input  logic          ex_store,
  input  logic [RW-1:0] ex_dst,
  input  logic          ex_wr,
  input  logic          ex_load,
  input  logic [RW-1:0] mem_dst,
  input  logic          mem_wr,
  input  logic          mem_load,
  input  logic [DW-1:0] mem_alu_val,
  input  logic [RW-1:0] wb_dst,
  input  logic          wb_wr,
  output logic [1:0]    fwd_a,
  output logic [1:0]    fwd_b,
  output logic [1:0]    fwd_st,
  output logic          stall_fd,
  output logic          bubble_ex,
  output logic          br_flush
);
  localparam int NOPS = 3;

  // registered mode: a change applies from the next cycle
  logic bypass_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bypass_q <= 1'b1;
    else        bypass_q <= bypass_en;
  end

  br_kind_e kind;
  assign kind = br_kind_e'(id_br);

  logic [RW-1:0] op_src   [NOPS];
  logic          op_reads [NOPS];
  fwd_sel_e      op_sel   [NOPS];

  assign op_src[0] = ex_src_a;  assign op_reads[0] = ex_use_a;
  assign op_src[1] = ex_src_b;  assign op_reads[1] = ex_use_b;
  assign op_src[2] = ex_src_b;  assign op_reads[2] = ex_store;

  for (genvar k = 0; k < NOPS; k++) begin : g_op
    hfu_op_fwd #(.RW(RW)) u_fwd (
      .src      (op_src[k]),
      .reads    (op_reads[k]),
      .bypass_on(bypass_q),
      .mem_dst  (mem_dst),
      .mem_wr   (mem_wr),
      .mem_load (mem_load),
      .wb_dst   (wb_dst),
      .wb_wr    (wb_wr),
      .sel      (op_sel[k])
    );
  end

  assign fwd_a  = op_sel[0];
  assign fwd_b  = op_sel[1];
  assign fwd_st = op_sel[2];

  logic hold;
  hfu_stall_ctl #(.RW(RW)) u_stall (
    .id_src_a (id_src_a),
    .id_src_b (id_src_b),
    .id_use_a (id_use_a),
    .id_use_b (id_use_b),
    .id_is_br (kind != BR_NONE),
    .bypass_on(bypass_q),
    .ex_dst   (ex_dst),
    .ex_wr    (ex_wr),
    .ex_load  (ex_load),
    .mem_dst  (mem_dst),
    .mem_wr   (mem_wr),
    .mem_load (mem_load),
    .stall    (hold)
  );

  assign stall_fd  = hold;
  assign bubble_ex = hold;

  hfu_branch_cmp #(.RW(RW), .DW(DW)) u_br (
    .kind       (kind),
    .src_a      (id_src_a),
    .src_b      (id_src_b),
    .rf_a       (id_rf_a),
    .rf_b       (id_rf_b),
    .bypass_on  (bypass_q),
    .mem_dst    (mem_dst),
    .mem_wr     (mem_wr),
    .mem_load   (mem_load),
    .mem_alu_val(mem_alu_val),
    .stall      (hold),
    .flush      (br_flush)
  );
endmodule

// File: rtl/hfu_checker.sv
module hfu_checker #(
  parameter int RW = 5
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bypass_q,
  input logic [RW-1:0] id_src_a,
  input logic          id_use_a,
  input logic [RW-1:0] ex_src_a,
  input logic [RW-1:0] ex_dst,
  input logic          ex_wr,
  input logic          ex_load,
  input logic [RW-1:0] mem_dst,
  input logic          mem_wr,
  input logic          mem_load,
  input logic [1:0]    fwd_a,
  input logic [1:0]    fwd_b,
  input logic [1:0]    fwd_st,
  input logic          stall_fd,
  input logic          bubble_ex,
  input logic          br_flush
);
  // R8
  flush_not_stalled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    br_flush |-> !stall_fd);

  // R3
  zero_reg_fwd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_src_a == '0) |-> (fwd_a == 2'b00));

  // R7
  no_bypass_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bypass_q |-> (fwd_a == 2'b00 && fwd_b == 2'b00 && fwd_st == 2'b00));

  // R6
  load_use_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ex_wr && ex_load && ex_dst != '0 && id_use_a && id_src_a == ex_dst)
      |-> (stall_fd && bubble_ex));

  // R1
  mem_sel_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fwd_a == 2'b01) |-> (mem_wr && !mem_load && mem_dst == ex_src_a));
endmodule

bind hazard_fwd_unit hfu_checker #(.RW(RW)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bypass_q (bypass_q),
  .id_src_a (id_src_a),
  .id_use_a (id_use_a),
  .ex_src_a (ex_src_a),
  .ex_dst   (ex_dst),
  .ex_wr    (ex_wr),
  .ex_load  (ex_load),
  .mem_dst  (mem_dst),
  .mem_wr   (mem_wr),
  .mem_load (mem_load),
  .fwd_a    (fwd_a),
  .fwd_b    (fwd_b),
  .fwd_st   (fwd_st),
  .stall_fd (stall_fd),
  .bubble_ex(bubble_ex),
  .br_flush (br_flush)
);

// File: tb/hazard_fwd_unit_tb_top.sv
module hazard_fwd_unit_tb_top;
  localparam int RW = 5;
  localparam int DW = 32;
  localparam int WATCHDOG = 5000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2.5 clk = ~clk;

  logic          bypass_en;
  logic [RW-1:0] id_src_a, id_src_b, ex_src_a, ex_src_b, ex_dst, mem_dst, wb_dst;
  logic          id_use_a, id_use_b, ex_use_a, ex_use_b, ex_store;
  logic          ex_wr, ex_load, mem_wr, mem_load, wb_wr;
  logic [1:0]    id_br;
  logic [DW-1:0] id_rf_a, id_rf_b, mem_alu_val;
  logic [1:0]    fwd_a, fwd_b, fwd_st;
  logic          stall_fd, bubble_ex, br_flush;

  hazard_fwd_unit #(.RW(RW), .DW(DW)) dut_i (
    .clk(clk), .rst_n(rst_n), .bypass_en(bypass_en),
    .id_src_a(id_src_a), .id_src_b(id_src_b), .id_use_a(id_use_a), .id_use_b(id_use_b),
    .id_br(id_br), .id_rf_a(id_rf_a), .id_rf_b(id_rf_b),
    .ex_src_a(ex_src_a), .ex_src_b(ex_src_b), .ex_use_a(ex_use_a), .ex_use_b(ex_use_b),
    .ex_store(ex_store), .ex_dst(ex_dst), .ex_wr(ex_wr), .ex_load(ex_load),
    .mem_dst(mem_dst), .mem_wr(mem_wr), .mem_load(mem_load), .mem_alu_val(mem_alu_val),
    .wb_dst(wb_dst), .wb_wr(wb_wr),
    .fwd_a(fwd_a), .fwd_b(fwd_b), .fwd_st(fwd_st),
    .stall_fd(stall_fd), .bubble_ex(bubble_ex), .br_flush(br_flush)
  );

  typedef struct {
    logic [1:0] fa, fb, fs;
    logic       stall, flush;
    string      req;
  } exp_t;

  exp_t exp_q[$];
  int   n_checks = 0;
  int   n_fail   = 0;
  bit   done     = 1'b0;

  task automatic idle();
    id_src_a = '0; id_src_b = '0; id_use_a = 0; id_use_b = 0; id_br = 2'b00;
    id_rf_a = '0; id_rf_b = '0;
    ex_src_a = '0; ex_src_b = '0; ex_use_a = 0; ex_use_b = 0; ex_store = 0;
    ex_dst = '0; ex_wr = 0; ex_load = 0;
    mem_dst = '0; mem_wr = 0; mem_load = 0; mem_alu_val = '0;
    wb_dst = '0; wb_wr = 0;
  endtask

  // driver: caller has just set the inputs after a rising edge; queue expectation
  task automatic expect_now(input logic [1:0] fa, input logic [1:0] fb,
                            input logic [1:0] fs, input logic st,
                            input logic fl, input string req);
    exp_t e;
    e.fa = fa; e.fb = fb; e.fs = fs; e.stall = st; e.flush = fl; e.req = req;
    exp_q.push_back(e);
  endtask

  task automatic next_cycle();
    @(posedge clk);
    #1;
    idle();
  endtask

  // monitor
  always @(negedge clk) begin
    if (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      n_checks++;
      if (fwd_a !== e.fa || fwd_b !== e.fb || fwd_st !== e.fs ||
          stall_fd !== e.stall || bubble_ex !== e.stall || br_flush !== e.flush) begin
        n_fail++;
        $display("FAIL %s: actual a=%b b=%b st=%b stall=%b bub=%b flush=%b expected a=%b b=%b st=%b stall=%b bub=%b flush=%b",
                 e.req, fwd_a, fwd_b, fwd_st, stall_fd, bubble_ex, br_flush,
                 e.fa, e.fb, e.fs, e.stall, e.stall, e.flush);
      end
    end
  end

  initial begin
    for (int i = 0; i < WATCHDOG; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    bypass_en = 1'b1;
    idle();
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // reset state: idle pipeline, bypass on
    next_cycle();
    expect_now(2'b00, 2'b00, 2'b00, 0, 0, "reset");

    // R1: memory-stage ALU result to operand A
    next_cycle();
    ex_src_a = 5'd3; ex_use_a = 1; mem_dst = 5'd3; mem_wr = 1;
    expect_now(2'b01, 2'b00, 2'b00, 0, 0, "R1");

    // R2: writeback result to operand B
    next_cycle();
    ex_src_b = 5'd4; ex_use_b = 1; wb_dst = 5'd4; wb_wr = 1;
    expect_now(2'b00, 2'b10, 2'b00, 0, 0, "R2");

    // R2: memory stage wins over writeback
    next_cycle();
    ex_src_a = 5'd5; ex_use_a = 1; mem_dst = 5'd5; mem_wr = 1; wb_dst = 5'd5; wb_wr = 1;
    expect_now(2'b01, 2'b00, 2'b00, 0, 0, "R2 priority");

    // R3: register 0 never bypassed nor stalled on
    next_cycle();
    ex_src_a = 5'd0; ex_use_a = 1; mem_dst = 5'd0; mem_wr = 1;
    id_src_a = 5'd0; id_use_a = 1; ex_dst = 5'd0; ex_wr = 1; ex_load = 1;
    expect_now(2'b00, 2'b00, 2'b00, 0, 0, "R3");

    // R4: store data bypass while operand B uses an immediate
    next_cycle();
    ex_store = 1; ex_src_b = 5'd6; mem_dst = 5'd6; mem_wr = 1;
    expect_now(2'b00, 2'b00, 2'b01, 0, 0, "R4");

    // R5: writeback to decode reader needs nothing
    next_cycle();
    id_src_a = 5'd7; id_use_a = 1; wb_dst = 5'd7; wb_wr = 1;
    expect_now(2'b00, 2'b00, 2'b00, 0, 0, "R5");

    // R6: load-use sequence over three cycles
    next_cycle();
    id_src_b = 5'd8; id_use_b = 1; ex_dst = 5'd8; ex_wr = 1; ex_load = 1;
    expect_now(2'b00, 2'b00, 2'b00, 1, 0, "R6 hold");
    next_cycle();
    id_src_b = 5'd8; id_use_b = 1; mem_dst = 5'd8; mem_wr = 1; mem_load = 1;
    expect_now(2'b00, 2'b00, 2'b00, 0, 0, "R6 release");
    next_cycle();
    ex_src_b = 5'd8; ex_use_b = 1; wb_dst = 5'd8; wb_wr = 1;
    expect_now(2'b00, 2'b10, 2'b00, 0, 0, "R6 load value");

    // R8: comparator kinds
    next_cycle();
    id_br = 2'b01; id_src_a = 5'd1; id_src_b = 5'd2; id_rf_a = 32'd5; id_rf_b = 32'd5;
    expect_now(2'b00, 2'b00, 2'b00, 0, 1, "R8 eq taken");
    next_cycle();
    id_br = 2'b10; id_src_a = 5'd1; id_src_b = 5'd2; id_rf_a = 32'd5; id_rf_b = 32'd5;
    expect_now(2'b00, 2'b00, 2'b00, 0, 0, "R8 ne not taken");
    next_cycle();
    id_br = 2'b10; id_src_a = 5'd1; id_src_b = 5'd2; id_rf_a = 32'd5; id_rf_b = 32'd6;
    expect_now(2'b00, 2'b00, 2'b00, 0, 1, "R8 ne taken");

    // R9: comparator bypass from memory-stage ALU result
    next_cycle();
    id_br = 2'b01; id_src_a = 5'd9; id_src_b = 5'd10; id_rf_a = 32'd0; id_rf_b = 32'd42;
    mem_dst = 5'd9; mem_wr = 1; mem_alu_val = 32'd42;
    expect_now(2'b00, 2'b00, 2'b00, 0, 1, "R9");

    // R10: branch waits on ALU in execute, flush withheld
    next_cycle();
    id_br = 2'b01; id_src_a = 5'd9; id_src_b = 5'd10; id_rf_a = 32'd3; id_rf_b = 32'd3;
    ex_dst = 5'd9; ex_wr = 1;
    expect_now(2'b00, 2'b00, 2'b00, 1, 0, "R10 ex alu");
    next_cycle();
    id_br = 2'b01; id_src_a = 5'd9; id_src_b = 5'd10; id_rf_a = 32'd3; id_rf_b = 32'd3;
    mem_dst = 5'd10; mem_wr = 1; mem_load = 1;
    expect_now(2'b00, 2'b00, 2'b00, 1, 0, "R10 mem load");

    // R7: turn bypassing off; old mode still applies this cycle
    next_cycle();
    bypass_en = 1'b0;
    ex_src_a = 5'd3; ex_use_a = 1; mem_dst = 5'd3; mem_wr = 1;
    expect_now(2'b01, 2'b00, 2'b00, 0, 0, "R7 old mode");
    next_cycle();
    ex_src_a = 5'd3; ex_use_a = 1; mem_dst = 5'd3; mem_wr = 1;
    expect_now(2'b00, 2'b00, 2'b00, 0, 0, "R7 selects off");
    // dependent directly behind producer: two stalled cycles then go
    next_cycle();
    id_src_a = 5'd11; id_use_a = 1; ex_dst = 5'd11; ex_wr = 1;
    expect_now(2'b00, 2'b00, 2'b00, 1, 0, "R7 stall 1");
    next_cycle();
    id_src_a = 5'd11; id_use_a = 1; mem_dst = 5'd11; mem_wr = 1;
    expect_now(2'b00, 2'b00, 2'b00, 1, 0, "R7 stall 2");
    next_cycle();
    id_src_a = 5'd11; id_use_a = 1; wb_dst = 5'd11; wb_wr = 1;
    expect_now(2'b00, 2'b00, 2'b00, 0, 0, "R7 proceed");
    // restore bypassing
    next_cycle();
    bypass_en = 1'b1;
    next_cycle();
    ex_src_b = 5'd12; ex_use_b = 1; mem_dst = 5'd12; mem_wr = 1;
    expect_now(2'b00, 2'b01, 2'b00, 0, 0, "R7 restored");

    next_cycle();
    @(negedge clk);
    #1;
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule